// File: doc/BRIEF.md
# RTC Interrupt Flag Generator

This block produces the three interrupt sources of a real-time clock (periodic, alarm and update-ended) and the interrupt request that goes with them. A timekeeping engine drives it. On each update step the engine gives the number of microseconds that have passed since the previous step. It also gives a strobe that marks whether a whole second rolled over during that step, the current and alarm time bytes, and the contents of control registers A and B. Calendar arithmetic and register storage are handled elsewhere.

On every update step the block clears its flag byte and evaluates it again. The periodic source keeps a microsecond accumulator and compares it with an interval taken from a 4-bit rate code. When the interval is reached, the block takes the interval off and keeps what is left over. The alarm source compares hours, minutes and seconds with the alarm bytes, but only in a step that rolled over a second. The update source fires on every step while it is enabled. The resulting flag byte is presented as status register C. One cycle after C changes, a one-cycle interrupt pulse follows if the summary flag is set.

Top module: `rtc_irq_flags`

## Requirements
- R1: After reset, `reg_c` reads 0x00, `irq_pulse` is low and the periodic accumulator is empty.
- R2: The periodic interval in microseconds is 1000000 / (65536 >> rate), with integer division, where rate is `reg_a[3:0]`. Rate 0 gives 15 us, rate 6 gives 976 us and rate 15 gives 500000 us.
- R3: While the periodic enable `reg_b[6]` is set, each step adds `step_us` to the accumulator. If the sum is greater than or equal to the interval, PF (`reg_c[6]`) is set and the interval is subtracted, keeping the remainder.
- R4: While `reg_b[6]` is clear, the accumulator is held at zero and PF stays clear, so setting the enable again starts a fresh interval.
- R5: AF (`reg_c[5]`) is set in a step only when `sec_roll` is high, the alarm enable `reg_b[5]` is set, and seconds, minutes and hours all equal their alarm bytes.
- R6: UF (`reg_c[4]`) is set in every step while the update enable `reg_b[4]` is set.
- R7: Each step clears bits [7:4] of `reg_c` before they are evaluated again. Bits [3:0] always read 0. Without a step, `reg_c` holds its value.
- R8: IRQF (`reg_c[7]`) is the OR of PF, AF and UF.
- R9: In the cycle after a step updates `reg_c`, `irq_pulse` is high for exactly one cycle if IRQF is set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | One-cycle update step strobe |
| step_us | input | STEP_W | Microseconds elapsed in this step |
| sec_roll | input | 1 | A second rolled over in this step |
| now_sec | input | 8 | Current seconds byte |
| now_min | input | 8 | Current minutes byte |
| now_hour | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hour | input | 8 | Alarm hours byte |
| reg_a | input | 8 | Control register A (rate code in [3:0]) |
| reg_b | input | 8 | Control register B (enables in [6:4]) |
| reg_c | output | 8 | Flag register C |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The assertions assume that `step_valid` is a clean strobe, sampled only at clock edges. They also assume that the control and time inputs are stable around the edge where a step is taken. They further assume that elapsed time per step stays small enough for the accumulator never to wrap. The stimulus meets these assumptions by driving every input on the falling edge. Its random phase limits steps to at most 200 us and rates to 4 or more, so the remainder stays bounded even when the rate changes while the periodic source is enabled.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int unsigned US_PER_SEC = 1000000;
    localparam int unsigned BASE_HZ    = 65536;
    localparam int unsigned RATE_W     = 4;
    localparam int unsigned RATE_CNT   = 1 << RATE_W;

    // Flag and enable bit positions (shared by registers B and C)
    localparam int unsigned IRQF_BIT = 7;
    localparam int unsigned PER_BIT  = 6;
    localparam int unsigned ALM_BIT  = 5;
    localparam int unsigned UPD_BIT  = 4;

    function automatic int unsigned interval_us(input int unsigned rate);
        return US_PER_SEC / (BASE_HZ >> rate);
    endfunction

    typedef struct packed {
        logic [7:0] c;
        logic       pend;
        logic       irq;
    } flag_state_t;
endpackage

// File: rtl/rtc_periodic_acc.sv
module rtc_periodic_acc
    import rtc_irq_pkg::*;
#(
    parameter int unsigned STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_valid,
    input  logic [STEP_W-1:0] step_us,
    input  logic              pi_en,
    input  logic [RATE_W-1:0] rate,
    output logic              pf_hit
);
    localparam int unsigned ACC_W = ((STEP_W > 19) ? STEP_W : 19) + 2;

    logic [ACC_W-1:0] interval_tab [RATE_CNT];
    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] interval;

    for (genvar gi = 0; gi < RATE_CNT; gi++) begin : g_tab
        assign interval_tab[gi] = ACC_W'(interval_us(gi));
    end

    always_comb begin
        interval = interval_tab[rate];
        sum      = acc_q + ACC_W'(step_us);
        pf_hit   = step_valid && pi_en && (sum >= interval);
        acc_d    = acc_q;
        if (!pi_en) begin
            acc_d = '0;
        end else if (step_valid) begin
            acc_d = pf_hit ? (sum - interval) : sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int unsigned FIELDS = 3,
    parameter int unsigned TIME_W = 8
) (
    input  logic [FIELDS-1:0][TIME_W-1:0] now_vals,
    input  logic [FIELDS-1:0][TIME_W-1:0] alm_vals,
    output logic                          match
);
    logic [FIELDS-1:0] field_eq;

    for (genvar gf = 0; gf < FIELDS; gf++) begin : g_cmp
        assign field_eq[gf] = (now_vals[gf] == alm_vals[gf]);
    end

    assign match = &field_eq;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
#(
    parameter int unsigned STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_valid,
    input  logic [STEP_W-1:0] step_us,
    input  logic              sec_roll,
    input  logic [7:0]        now_sec,
    input  logic [7:0]        now_min,
    input  logic [7:0]        now_hour,
    input  logic [7:0]        alm_sec,
    input  logic [7:0]        alm_min,
    input  logic [7:0]        alm_hour,
    input  logic [7:0]        reg_a,
    input  logic [7:0]        reg_b,
    output logic [7:0]        reg_c,
    output logic              irq_pulse
);
    localparam int unsigned FIELDS = 3;
    localparam int unsigned TIME_W = 8;

    flag_state_t st_d, st_q;
    logic        pf_hit;
    logic        alarm_match;
    logic        unused_bits;

    assign unused_bits = ^{reg_a[7:RATE_W], reg_b[7], reg_b[3:0]};

    rtc_periodic_acc #(.STEP_W(STEP_W)) u_per (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_valid (step_valid),
        .step_us    (step_us),
        .pi_en      (reg_b[PER_BIT]),
        .rate       (reg_a[RATE_W-1:0]),
        .pf_hit     (pf_hit)
    );

    rtc_alarm_match #(.FIELDS(FIELDS), .TIME_W(TIME_W)) u_alm (
        .now_vals ({now_hour, now_min, now_sec}),
        .alm_vals ({alm_hour, alm_min, alm_sec}),
        .match    (alarm_match)
    );

    always_comb begin
        st_d      = st_q;
        st_d.irq  = st_q.pend & st_q.c[IRQF_BIT];
        st_d.pend = step_valid;
        if (step_valid) begin
            st_d.c           = '0;
            st_d.c[PER_BIT]  = pf_hit;
            st_d.c[ALM_BIT]  = sec_roll & reg_b[ALM_BIT] & alarm_match;
            st_d.c[UPD_BIT]  = reg_b[UPD_BIT];
            st_d.c[IRQF_BIT] = st_d.c[PER_BIT] | st_d.c[ALM_BIT] | st_d.c[UPD_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_c     = st_q.c;
    assign irq_pulse = st_q.irq;
endmodule

// File: rtl/rtc_irq_flags_chk.sv
module rtc_irq_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       step_valid,
    input logic       sec_roll,
    input logic [7:0] reg_b,
    input logic [7:0] reg_c,
    input logic       irq_pulse
);
    // R7
    low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_c[3:0] == 4'h0);
    // R7
    c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> $stable(reg_c));
    // R8
    irqf_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_c[7] == (reg_c[6] | reg_c[5] | reg_c[4]));
    // R6
    uf_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && reg_b[4]) |=> reg_c[4]);
    // R5
    af_needs_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !sec_roll) |=> !reg_c[5]);
    // R4
    pf_needs_pi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !reg_b[6]) |=> !reg_c[6]);
    // R9
    irq_follows_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && reg_b[4]) |=> ##1 irq_pulse);
    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(reg_c[7]));
endmodule

bind rtc_irq_flags rtc_irq_flags_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_valid (step_valid),
    .sec_roll   (sec_roll),
    .reg_b      (reg_b),
    .reg_c      (reg_c),
    .irq_pulse  (irq_pulse)
);

// File: tb/rtc_irq_flags_test.sv
`timescale 1ns/1ps
module rtc_irq_flags_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_valid = 1'b0;
    logic [15:0] step_us = '0;
    logic        sec_roll = 1'b0;
    logic [7:0]  now_sec = '0, now_min = '0, now_hour = '0;
    logic [7:0]  alm_sec = '0, alm_min = '0, alm_hour = '0;
    logic [7:0]  reg_a = 8'h26, reg_b = 8'h00;
    logic [7:0]  reg_c;
    logic        irq_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference
    int m_acc = 0;
    int m_c = 0;
    bit m_pend = 0, m_irq = 0;

    always #2.5 clk = ~clk;

    rtc_irq_flags uut (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_us(step_us),
        .sec_roll(sec_roll), .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .irq_pulse(irq_pulse)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_c = 0; m_pend = 0; m_irq = 0;
        end else begin
            int iv;
            int c;
            m_irq  = m_pend && m_c[7];
            m_pend = step_valid;
            if (!reg_b[6]) m_acc = 0;
            if (step_valid) begin
                c = 0;
                if (reg_b[6]) begin
                    m_acc += int'(step_us);
                    iv = 1000000 / (65536 >> reg_a[3:0]);
                    if (m_acc >= iv) begin
                        c |= 'h40;
                        m_acc -= iv;
                    end
                end
                if (sec_roll && reg_b[5] && now_sec == alm_sec &&
                    now_min == alm_min && now_hour == alm_hour) c |= 'h20;
                if (reg_b[4]) c |= 'h10;
                if (c != 0) c |= 'h80;
                m_c = c;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R7 flags, R9 pulse)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 model reg_c", int'(reg_c), m_c);
            chk("R9 model irq_pulse", int'(irq_pulse), int'(m_irq));
        end
    end

    task automatic do_step(input int us, input bit roll);
        @(negedge clk);
        step_valid = 1'b1; step_us = 16'(us); sec_roll = roll;
        @(negedge clk);
        step_valid = 1'b0; sec_roll = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset reg_c", int'(reg_c), 0);
        chk("R1 reset irq", int'(irq_pulse), 0);

        // R3: rate 6 -> 976 us, steps of 100
        reg_a = 8'h26; reg_b = 8'h40;
        for (int i = 0; i < 9; i++) begin
            do_step(100, 0);
            chk("R3 below interval", int'(reg_c), 'h00);
        end
        do_step(100, 0);
        chk("R3 interval reached", int'(reg_c), 'hC0);
        @(negedge clk);
        chk("R9 pulse after C", int'(irq_pulse), 1);
        @(negedge clk);
        chk("R9 pulse one cycle", int'(irq_pulse), 0);
        do_step(952, 0);
        chk("R3 remainder kept, equal hits", int'(reg_c), 'hC0);

        // R2: rate 0 -> 15 us
        reg_b = 8'h00; idle(2);
        reg_a = 8'h20; reg_b = 8'h40;
        do_step(14, 0);
        chk("R2 rate0 below", int'(reg_c), 'h00);
        do_step(1, 0);
        chk("R2 rate0 at 15", int'(reg_c), 'hC0);

        // R2: rate 15 -> 500000 us
        reg_b = 8'h00; idle(2);
        reg_a = 8'h2F; reg_b = 8'h40;
        for (int i = 0; i < 7; i++) do_step(65535, 0);
        chk("R2 rate15 below", int'(reg_c), 'h00);
        do_step(65535, 0);
        chk("R2 rate15 reached", int'(reg_c), 'hC0);

        // R4: disabling clears accumulator
        reg_b = 8'h00; idle(2);
        reg_a = 8'h26; reg_b = 8'h40;
        do_step(900, 0);
        reg_b = 8'h00;
        do_step(5000, 0);
        chk("R4 PF clear when PI off", int'(reg_c), 'h00);
        reg_b = 8'h40;
        do_step(100, 0);
        chk("R4 fresh interval", int'(reg_c), 'h00);

        // R6 / R7
        reg_b = 8'h10;
        do_step(0, 0);
        chk("R6 update flag", int'(reg_c), 'h90);
        idle(3);
        chk("R7 hold without step", int'(reg_c), 'h90);
        chk("R9 no second pulse", int'(irq_pulse), 0);
        reg_b = 8'h00;
        do_step(0, 0);
        chk("R7 flags cleared per step", int'(reg_c), 'h00);

        // R5 alarm
        now_sec = 8'h30; now_min = 8'h15; now_hour = 8'h09;
        alm_sec = 8'h30; alm_min = 8'h15; alm_hour = 8'h09;
        reg_b = 8'h20;
        do_step(10, 1);
        chk("R5 alarm match", int'(reg_c), 'hA0);
        do_step(10, 0);
        chk("R5 no roll no AF", int'(reg_c), 'h00);
        alm_min = 8'h16;
        do_step(10, 1);
        chk("R5 minute mismatch", int'(reg_c), 'h00);
        alm_min = 8'h15; reg_b = 8'h00;
        do_step(10, 1);
        chk("R5 AI off", int'(reg_c), 'h00);

        // R8 all sources together
        reg_b = 8'h00; idle(2);
        reg_a = 8'h20; reg_b = 8'h70;
        do_step(15, 1);
        chk("R8 all flags", int'(reg_c), 'hF0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            step_valid = ($urandom_range(0, 2) != 0);
            step_us    = 16'($urandom_range(0, 200));
            sec_roll   = ($urandom_range(0, 3) == 0);
            now_sec    = 8'($urandom_range(0, 2));
            alm_sec    = 8'($urandom_range(0, 2));
            if ($urandom_range(0, 50) == 0) reg_a = 8'($urandom_range(4, 8));
            if ($urandom_range(0, 20) == 0) reg_b = 8'($urandom_range(0, 255));
        end
        step_valid = 1'b0;
        idle(3);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule